// File: doc/BRIEF.md
# Phase-Offset Pulse Width Modulator

This block is one channel of a pulse width modulator. A free-running cycle counter counts from zero up to a programmed period. The output pulse rises when the counter reaches a programmed phase offset and stays high for a programmed width. The block derives both edges from those two values, so either one can be changed while the other stays fixed. Period, phase and width are loaded into a pending set by a write strobe. The pending set is copied into the working set only at the start of a cycle, so a write never breaks the pulse in the middle of a cycle. A select input can replace the channel's own width with a master width that several channels share.

A cycle starts in one of two ways. In self mode the channel restarts on its own when its count completes. In host mode it starts only on a start-of-cycle trigger from another channel. In host mode the counter stops at the period and waits for the next trigger. A trigger that arrives while a cycle is still counting is dropped. The channel sends out its own one-clock start pulse, so a host can drive any number of client channels. A client that is enabled before its host stays idle, which lets a group of channels start on the same edge.

Top module: `vphase_pwm`

## Requirements
- R1: While `rst_n` is low, `pwm_out` and `soc_out` are low.
- R2: In self mode (`trig_sel`=0) a cycle lasts period+1 clocks. `soc_out` is high for one clock at the start of each cycle, and the counter never goes past the period.
- R3: Number the clocks from 0 at the one where `soc_out` is high. `pwm_out` goes high at index phase+1 and stays high for duty clocks when phase+duty ≤ period. It is always low at index 0.
- R4: If phase+duty exceeds the period, the pulse ends at the end of the cycle, so its width is period−phase. If phase ≥ period, there is no pulse.
- R5: Values written with `cfg_wr` take effect at the next cycle start. The cycle already running keeps its old phase, width and period.
- R6: With `mdc_sel`=1 at a cycle start, that cycle uses `master_duty` as its width in place of the channel's own duty value.
- R7: In host mode (`trig_sel`=1), an enabled channel that has received no trigger produces no `soc_out` and no pulse.
- R8: In host mode a cycle starts only on a `host_soc_in` pulse. The pulse is accepted while the channel is idle or on the clock where the counter equals the period. It is ignored at any other time while counting.
- R9: In host mode, when the counter reaches the period with no trigger present, the channel stops and stays idle with its output low.
- R10: While `enable` is low, the counter is held at zero, and one clock later `pwm_out` and `soc_out` are low.
- R11: When `out_en` is low, `pwm_out` is low one clock later, while the counter and `soc_out` keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Channel run enable |
| out_en | input | 1 | Output pin enable |
| trig_sel | input | 1 | Cycle start source: 0 = self, 1 = host trigger |
| host_soc_in | input | 1 | Start-of-cycle trigger from a host channel |
| cfg_wr | input | 1 | Write strobe for period, phase and duty |
| per_in | input | CNT_W | Period value (last count of the cycle) |
| phase_in | input | CNT_W | Phase offset of the rising edge |
| duty_in | input | CNT_W | Pulse width |
| mdc_sel | input | 1 | Use the shared master width |
| master_duty | input | CNT_W | Shared master width |
| pwm_out | output | 1 | Pulse output |
| soc_out | output | 1 | One-clock start-of-cycle pulse |

## Verification
A counter that has lost track of its position shows up as a wrong spacing between `soc_out` pulses, within one period. A wrong value in the working registers shows up as a shifted rising edge or a wrong pulse width, within the cycle in which it is loaded. A wrong idle or running flag in host mode shows up as an extra or a missing `soc_out`, either when a trigger is dropped or when the counter reaches the period.

// File: rtl/vpp_pkg.sv
// Shared definitions for the phase-offset PWM channel.
// Assumes: nothing beyond IEEE 1800-2017.
package vpp_pkg;
    typedef enum logic {
        TRIG_SELF = 1'b0,
        TRIG_HOST = 1'b1
    } trig_src_e;
endpackage

// File: rtl/vpp_shadow.sv
// Pending and working copies of period, phase and width.
// cfg_wr captures the inputs into the pending set. load (cycle start)
// copies the pending set into the working set and picks master or own width.
// Assumes: load is a single-cycle strobe from the timebase.
module vpp_shadow #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] per_in,
    input  logic [CNT_W-1:0] phase_in,
    input  logic [CNT_W-1:0] duty_in,
    input  logic             mdc_sel,
    input  logic [CNT_W-1:0] master_duty,
    input  logic             load,
    output logic [CNT_W-1:0] per_a,
    output logic [CNT_W-1:0] phase_a,
    output logic [CNT_W-1:0] duty_a
);
    logic [CNT_W-1:0] per_p, phase_p, duty_p;

    // Capture software values into the pending set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_p   <= '0;
            phase_p <= '0;
            duty_p  <= '0;
        end else if (cfg_wr) begin
            per_p   <= per_in;
            phase_p <= phase_in;
            duty_p  <= duty_in;
        end
    end

    // Promote the pending set to the working set at cycle start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_a   <= '0;
            phase_a <= '0;
            duty_a  <= '0;
        end else if (load) begin
            per_a   <= per_p;
            phase_a <= phase_p;
            duty_a  <= mdc_sel ? master_duty : duty_p;
        end
    end
endmodule

// File: rtl/vpp_timebase.sv
// Cycle counter and start-of-cycle logic.
// Self mode restarts at the period; host mode stops at the period and
// waits for a trigger. A trigger is taken when idle or at the last count.
// Assumes: per_a changes only on the clock where start is high.
module vpp_timebase #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             host_mode,
    input  logic             host_soc_in,
    input  logic [CNT_W-1:0] per_a,
    output logic [CNT_W-1:0] cnt_q,
    output logic             run_q,
    output logic             start,
    output logic             soc_out
);
    logic at_end;
    logic may_start;

    // Decide whether a new cycle begins on this clock.
    always_comb begin
        at_end    = run_q && (cnt_q == per_a);
        may_start = !run_q || at_end;
        start     = enable && may_start && (!host_mode || host_soc_in);
    end

    // Advance, restart or park the counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q   <= '0;
            run_q   <= 1'b0;
            soc_out <= 1'b0;
        end else begin
            soc_out <= start;
            if (start) begin
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (at_end) begin
                cnt_q <= '0;
                run_q <= 1'b0;
            end else if (run_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vpp_edge.sv
// Edge generation: high for phase <= count < phase+duty, cut at period.
// The output is registered, so it lags the counter by one clock.
// Assumes: working values are stable while run is high between starts.
module vpp_edge #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             out_en,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] per_a,
    input  logic [CNT_W-1:0] phase_a,
    input  logic [CNT_W-1:0] duty_a,
    output logic             pwm_out
);
    localparam int unsigned SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] fall_pt;
    logic             in_pulse;

    // Compare the count against the derived rising and falling points.
    always_comb begin
        fall_pt  = {1'b0, phase_a} + {1'b0, duty_a};
        in_pulse = run && (cnt >= phase_a) && ({1'b0, cnt} < fall_pt)
                   && (cnt < per_a);
    end

    // Register the gated pulse onto the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_out <= 1'b0;
        else        pwm_out <= enable && out_en && in_pulse;
    end
endmodule

// File: rtl/vphase_pwm.sv
// Top of the phase-offset PWM channel: shadow registers, timebase, edges.
// Assumes: host_soc_in is synchronous to clk and one clock wide.
module vphase_pwm
    import vpp_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             out_en,
    input  logic             trig_sel,
    input  logic             host_soc_in,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] per_in,
    input  logic [CNT_W-1:0] phase_in,
    input  logic [CNT_W-1:0] duty_in,
    input  logic             mdc_sel,
    input  logic [CNT_W-1:0] master_duty,
    output logic             pwm_out,
    output logic             soc_out
);
    logic [CNT_W-1:0] per_a, phase_a, duty_a, cnt_q;
    logic             run_q, start, host_mode;

    // Decode the trigger source.
    always_comb host_mode = (trig_src_e'(trig_sel) == TRIG_HOST);

    vpp_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
        .per_in(per_in), .phase_in(phase_in), .duty_in(duty_in),
        .mdc_sel(mdc_sel), .master_duty(master_duty), .load(start),
        .per_a(per_a), .phase_a(phase_a), .duty_a(duty_a)
    );

    vpp_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .enable(enable), .host_mode(host_mode),
        .host_soc_in(host_soc_in), .per_a(per_a),
        .cnt_q(cnt_q), .run_q(run_q), .start(start), .soc_out(soc_out)
    );

    vpp_edge #(.CNT_W(CNT_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .enable(enable), .out_en(out_en),
        .run(run_q), .cnt(cnt_q), .per_a(per_a), .phase_a(phase_a),
        .duty_a(duty_a), .pwm_out(pwm_out)
    );
endmodule

// File: rtl/vpp_chk.sv
// Property checker for vphase_pwm, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module vpp_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             out_en,
    input logic             trig_sel,
    input logic             host_soc_in,
    input logic             pwm_out,
    input logic             soc_out,
    input logic             run_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] per_a
);
    assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= per_a));

    assert_low_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        soc_out |-> !pwm_out);

    assert_host_start_needs_trigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (soc_out && $past(trig_sel)) |-> $past(host_soc_in));

    assert_disable_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pwm_out && !soc_out));

    assert_pin_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> !pwm_out);
endmodule

bind vphase_pwm vpp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .out_en(out_en),
    .trig_sel(trig_sel), .host_soc_in(host_soc_in), .pwm_out(pwm_out),
    .soc_out(soc_out), .run_q(run_q), .cnt_q(cnt_q), .per_a(per_a)
);

// File: tb/vphase_pwm_tb.sv
`timescale 1ns/1ps
module vphase_pwm_tb;
    localparam int W = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, enable = 1'b0, out_en = 1'b1, trig_sel = 1'b0;
    logic host_soc_in = 1'b0, cfg_wr = 1'b0, mdc_sel = 1'b0;
    logic [W-1:0] per_in = '0, phase_in = '0, duty_in = '0, master_duty = '0;
    logic pwm_out, soc_out;

    vphase_pwm #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .out_en(out_en),
        .trig_sel(trig_sel), .host_soc_in(host_soc_in), .cfg_wr(cfg_wr),
        .per_in(per_in), .phase_in(phase_in), .duty_in(duty_in),
        .mdc_sel(mdc_sel), .master_duty(master_duty),
        .pwm_out(pwm_out), .soc_out(soc_out)
    );

    typedef struct {
        int    rise;
        int    width;
        int    len;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t e;
    int n_chk = 0, n_fail = 0;
    int soc_cnt = 0, hi_cnt = 0;
    int idx = 0, m_rise = -1, m_width = 0;
    bit open = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Monitor: measure each closed cycle and compare with the scoreboard.
    always @(negedge clk) begin
        if (pwm_out) hi_cnt++;
        if (!rst_n || !enable) begin
            open = 1'b0;
        end else begin
            if (soc_out) begin
                soc_cnt++;
                if (open && exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    if (e.len >= 0) chk(idx == e.len, e.tag, "cycle length", idx, e.len);
                    chk(m_width == e.width, e.tag, "pulse width", m_width, e.width);
                    if (e.width > 0) chk(m_rise == e.rise, e.tag, "rise index", m_rise, e.rise);
                end
                open = 1'b1; idx = 0; m_rise = -1; m_width = 0;
            end
            if (open) begin
                if (pwm_out) begin
                    if (m_rise < 0) m_rise = idx;
                    m_width++;
                end
                idx++;
            end
        end
    end

    function automatic int width_of(input int per, input int ph, input int du);
        int fall;
        if (ph >= per) return 0;
        fall = (ph + du > per) ? per : ph + du;
        return fall - ph;
    endfunction

    task automatic push(input int per, input int ph, input int du,
                        input int len, input string tag);
        exp_t x;
        x.width = width_of(per, ph, du);
        x.rise  = (x.width > 0) ? ph + 1 : -1;
        x.len   = len;
        x.tag   = tag;
        exp_q.push_back(x);
    endtask

    task automatic slot();
        @(posedge clk); #1;
    endtask

    task automatic setup(input int per, input int ph, input int du, input bit host,
                         input bit mds, input int md);
        slot(); enable = 1'b0;
        slot(); slot();
        per_in = per[W-1:0]; phase_in = ph[W-1:0]; duty_in = du[W-1:0];
        trig_sel = host; mdc_sel = mds; master_duty = md[W-1:0];
        cfg_wr = 1'b1;
        slot(); cfg_wr = 1'b0;
        soc_cnt = 0; hi_cnt = 0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) slot();
    endtask

    task automatic run_self(input int per, input int ph, input int du, input int n,
                            input string tag);
        setup(per, ph, du, 1'b0, 1'b0, 0);
        for (int i = 0; i < n; i++) push(per, ph, du, per + 1, tag);
        enable = 1'b1;
        drain();
    endtask

    task automatic trig();
        host_soc_in = 1'b1; slot(); host_soc_in = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (5) slot();
        // R1: outputs quiet in reset
        chk(pwm_out == 1'b0, "R1", "pwm_out in reset", pwm_out, 0);
        chk(soc_out == 1'b0, "R1", "soc_out in reset", soc_out, 0);
        rst_n = 1'b1;

        // R2 and R3: self mode, basic and zero phase
        run_self(15, 3, 5, 3, "R2/R3 basic");
        run_self(12, 0, 7, 2, "R3 zero phase");
        // R4: overflow cut at end of cycle, and phase beyond period
        run_self(10, 6, 9, 2, "R4 overflow");
        run_self(10, 12, 3, 2, "R4 phase past period");

        // R5: a write during a cycle applies only from the next cycle
        setup(15, 2, 4, 1'b0, 1'b0, 0);
        push(15, 2, 4, 16, "R5 old values");
        push(11, 5, 3, 12, "R5 new values");
        enable = 1'b1;
        do slot(); while (!soc_out);
        repeat (3) slot();
        per_in = 11; phase_in = 5; duty_in = 3; cfg_wr = 1'b1;
        slot(); cfg_wr = 1'b0;
        drain();

        // R6: master width replaces own width
        setup(14, 4, 2, 1'b0, 1'b1, 6);
        push(14, 4, 6, 15, "R6 master duty");
        push(14, 4, 6, 15, "R6 master duty");
        enable = 1'b1;
        drain();

        // R11: pin forced low, counter keeps running
        out_en = 1'b0;
        setup(9, 1, 3, 1'b0, 1'b0, 0);
        push(9, 9, 0, 10, "R11 out_en low");
        push(9, 9, 0, 10, "R11 out_en low");
        enable = 1'b1;
        drain();
        chk(hi_cnt == 0, "R11", "high clocks with out_en low", hi_cnt, 0);
        out_en = 1'b1;

        // R10: disable in mid pulse
        setup(20, 0, 20, 1'b0, 1'b0, 0);
        enable = 1'b1;
        repeat (6) slot();
        chk(pwm_out == 1'b1, "R10", "pulse before disable", pwm_out, 1);
        enable = 1'b0;
        slot();
        hi_cnt = 0; soc_cnt = 0;
        repeat (10) slot();
        chk(hi_cnt == 0, "R10", "high clocks while disabled", hi_cnt, 0);
        chk(soc_cnt == 0, "R10", "starts while disabled", soc_cnt, 0);

        // R7: host mode waits for its first trigger
        setup(19, 2, 5, 1'b1, 1'b0, 0);
        enable = 1'b1;
        repeat (40) slot();
        chk(soc_cnt == 0, "R7", "starts without trigger", soc_cnt, 0);
        chk(hi_cnt == 0, "R7", "high clocks without trigger", hi_cnt, 0);

        // R8 and R9: mid-cycle trigger dropped; stop at period
        push(19, 2, 5, 25, "R8/R9 ignored trigger");
        trig();
        repeat (7) slot();
        trig();
        repeat (16) slot();
        trig();
        drain();
        repeat (40) slot();
        hi_cnt = 0;
        repeat (20) slot();
        chk(soc_cnt == 2, "R9", "starts after last trigger", soc_cnt, 2);
        chk(hi_cnt == 0, "R9", "high clocks while parked", hi_cnt, 0);

        // R8: trigger on the last count restarts at once
        setup(9, 2, 3, 1'b1, 1'b0, 0);
        for (int i = 0; i < 3; i++) push(9, 2, 3, 10, "R8 last-count trigger");
        enable = 1'b1;
        for (int i = 0; i < 4; i++) begin
            trig();
            repeat (9) slot();
        end
        drain();
        chk(soc_cnt == 4, "R8", "starts for four triggers", soc_cnt, 4);

        enable = 1'b0;
        repeat (3) slot();
        report();
    end
endmodule